// File: doc/BRIEF.md
# Remote Link Register Access Bridge

This block gives a host a way to reach 32-bit registers that live on remote devices behind a request/response link. Software uses an indirect mailbox in the local window. It loads a target address (with a link index and per-byte write enables packed above the byte address), optionally loads write data, and then writes a command code. It polls a busy flag until the transfer is done. A read result is then available in a result register. Failed transfers raise a sticky error flag.

A second path serves host addresses whose top four bits are nonzero. Such an access becomes a full-word link transaction on the link named by host address bits 29:28. The host handshake is held off until the remote side answers. Host accesses with the top four bits zero reach only the local mailbox registers and never produce link traffic. A programmable response timeout keeps a silent remote side from hanging either path.

Top module: `rlink_bridge`

## Requirements
- R1: After reset the control/status register (byte offset 0x10) reads 0, the timeout register (offset 0x20) reads 1024, and no link request is issued.
- R2: Writing a value whose bits 1:0 are 01 to offset 0x10 while idle issues exactly one single-cycle link write. Its link index is address-register bits 25:24, its word address is address-register bits 15:2, its byte enables are address-register bits 19:16, and its data is the write-data register (offset 0x18). Status bit 0 reads 1 until the response.
- R3: Writing a value whose bits 1:0 are 11 to offset 0x10 while idle issues one link read with all byte enables set. After the response, status bit 0 reads 0 and offset 0x1C holds the returned word.
- R4: Bits 1:0 of the address register (offset 0x14) have no effect on the word address sent on the link.
- R5: A mailbox write changes only the bytes of the remote word whose enable bit is set; the other bytes keep their old value.
- R6: A command written while status bit 0 is 1 issues no request and leaves the transaction in flight unchanged.
- R7: If no response arrives within the timeout-register number of cycles, busy clears, status bit 15 is set, and a read returns 0xFFFFFFFF.
- R8: A response that carries the link error flag sets status bit 15.
- R9: Status bit 15 stays set until a write to offset 0x10 with bit 15 set clears it.
- R10: A host access with address bits 31:28 nonzero becomes a link transaction on link address bits 29:28, using all four byte enables and word address bits 15:2. The host handshake is withheld until the response, and read data is returned on the host port. An access with bits 31:28 zero touches only local registers.
- R11: The timeout register at offset 0x20 is writable and reads back the value written.
- R12: A control write whose bits 1:0 are 00 or 10 starts no transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_req | input | 1 | Host access request, held until h_ready |
| h_we | input | 1 | Host access is a write |
| h_addr | input | 30 | Host word address (byte address bits 31:2) |
| h_wdata | input | 32 | Host write data |
| h_ready | output | 1 | Host access completes this cycle |
| h_rdata | output | 32 | Host read data, valid with h_ready |
| l_req | output | 1 | Single-cycle link request pulse |
| l_we | output | 1 | Link request is a write |
| l_link | output | 2 | Target link index |
| l_addr | output | 14 | Remote word address |
| l_be | output | 4 | Remote byte enables |
| l_wdata | output | 32 | Remote write data |
| l_ack | input | 1 | Remote response pulse |
| l_err | input | 1 | Remote response reports an error, valid with l_ack |
| l_rdata | input | 32 | Remote read data, valid with l_ack |

## Verification
On every cycle the assertions check several properties. The link request must be a one-cycle pulse that only appears while the engine is busy. A command arriving during a transfer must never launch a second request. An expired timeout must leave the engine idle with the error flag set. The error flag must never drop without an explicit clear, and the timeout counter must never pass its latched limit. Only the bench scenarios can show end-to-end data effects: partial-byte merges at the remote word, ignored address low bits, error injection by the remote side, the exact field packing seen on the link, and direct-path read data.

// File: rtl/rlb_pkg.sv
package rlb_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } rlb_state_e;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_CTRL  = 3'd1,
        SEL_ADDR  = 3'd2,
        SEL_WDATA = 3'd3,
        SEL_RDATA = 3'd4,
        SEL_TMO   = 3'd5
    } rlb_sel_e;

    // word indices (byte offset >> 2) inside the local window
    localparam logic [5:0] WIDX_CTRL  = 6'h04;
    localparam logic [5:0] WIDX_ADDR  = 6'h05;
    localparam logic [5:0] WIDX_WDATA = 6'h06;
    localparam logic [5:0] WIDX_RDATA = 6'h07;
    localparam logic [5:0] WIDX_TMO   = 6'h08;

    localparam logic [1:0] CMD_WRITE = 2'b01;
    localparam logic [1:0] CMD_READ  = 2'b11;

    localparam int BUSY_BIT = 0;
    localparam int ERR_BIT  = 15;
    localparam int LINK_LSB = 24;

endpackage

// File: rtl/rlb_decode.sv
module rlb_decode
    import rlb_pkg::*;
(
    input  logic [31:2] h_addr,
    output logic        is_local,
    output logic [1:0]  link_sel,
    output rlb_sel_e    sel
);
    logic in_window;

    always_comb begin
        is_local  = (h_addr[31:28] == 4'd0);
        link_sel  = h_addr[29:28];
        in_window = is_local && (h_addr[27:8] == 20'd0);
        sel       = SEL_NONE;
        if (in_window) begin
            case (h_addr[7:2])
                WIDX_CTRL:  sel = SEL_CTRL;
                WIDX_ADDR:  sel = SEL_ADDR;
                WIDX_WDATA: sel = SEL_WDATA;
                WIDX_RDATA: sel = SEL_RDATA;
                WIDX_TMO:   sel = SEL_TMO;
                default:    sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/rlb_timer.sv
module rlb_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    typedef struct packed {
        logic [TMO_W-1:0] cnt;
        logic [TMO_W-1:0] lim;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (start) begin
            tmr_d.cnt = '0;
            tmr_d.lim = limit;
        end else if (run) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        expired = run && (tmr_q.cnt == tmr_q.lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R7: the wait counter never passes its latched limit
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (tmr_q.cnt <= tmr_q.lim));

endmodule

// File: rtl/rlink_bridge.sv
module rlink_bridge
    import rlb_pkg::*;
#(
    parameter int TMO_W     = 16,
    parameter int TMO_RESET = 1024,
    parameter int RADDR_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 h_req,
    input  logic                 h_we,
    input  logic [31:2]          h_addr,
    input  logic [31:0]          h_wdata,
    output logic                 h_ready,
    output logic [31:0]          h_rdata,
    output logic                 l_req,
    output logic                 l_we,
    output logic [1:0]           l_link,
    output logic [RADDR_W-3:0]   l_addr,
    output logic [3:0]           l_be,
    output logic [31:0]          l_wdata,
    input  logic                 l_ack,
    input  logic                 l_err,
    input  logic [31:0]          l_rdata
);
    localparam int WADDR_W = RADDR_W - 2;
    localparam int BE_LSB  = RADDR_W;

    typedef struct packed {
        rlb_state_e         st;
        logic               mb_owner;
        logic               we;
        logic [1:0]         link;
        logic [WADDR_W-1:0] waddr;
        logic [3:0]         be;
        logic [31:0]        wdata;
        logic               lreq;
        logic               err;
        logic [31:0]        mbox_addr;
        logic [31:0]        mbox_wdata;
        logic [31:0]        mbox_rdata;
        logic [TMO_W-1:0]   tmo;
        logic               dir_done;
        logic [31:0]        dir_rdata;
    } brg_t;

    brg_t     brg_d, brg_q;
    logic     is_local;
    logic [1:0] link_sel;
    rlb_sel_e sel;
    logic     issue;
    logic     expired;
    logic     run;
    logic     cmd_wr;
    logic [31:0] status;
    logic [31:0] local_rd;

    rlb_decode u_decode (
        .h_addr   (h_addr),
        .is_local (is_local),
        .link_sel (link_sel),
        .sel      (sel)
    );

    assign run = (brg_q.st == ST_WAIT);

    rlb_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (issue),
        .run     (run),
        .limit   (brg_q.tmo),
        .expired (expired)
    );

    always_comb begin
        status = '0;
        status[BUSY_BIT] = run;
        status[ERR_BIT]  = brg_q.err;
        case (sel)
            SEL_CTRL:  local_rd = status;
            SEL_ADDR:  local_rd = brg_q.mbox_addr;
            SEL_WDATA: local_rd = brg_q.mbox_wdata;
            SEL_RDATA: local_rd = brg_q.mbox_rdata;
            SEL_TMO:   local_rd = {{(32-TMO_W){1'b0}}, brg_q.tmo};
            default:   local_rd = '0;
        endcase
    end

    always_comb begin
        brg_d      = brg_q;
        brg_d.lreq = 1'b0;
        issue      = 1'b0;
        cmd_wr     = h_req && is_local && h_we && (sel == SEL_CTRL);

        if (h_req && is_local && h_we) begin
            case (sel)
                SEL_ADDR:  brg_d.mbox_addr  = h_wdata;
                SEL_WDATA: brg_d.mbox_wdata = h_wdata;
                SEL_TMO:   brg_d.tmo        = h_wdata[TMO_W-1:0];
                SEL_CTRL:  if (h_wdata[ERR_BIT]) brg_d.err = 1'b0;
                default: ;
            endcase
        end

        if (brg_q.dir_done && h_req) brg_d.dir_done = 1'b0;

        case (brg_q.st)
            ST_IDLE: begin
                if (cmd_wr && (h_wdata[1:0] == CMD_WRITE || h_wdata[1:0] == CMD_READ)) begin
                    issue          = 1'b1;
                    brg_d.st       = ST_WAIT;
                    brg_d.lreq     = 1'b1;
                    brg_d.mb_owner = 1'b1;
                    brg_d.we       = (h_wdata[1:0] == CMD_WRITE);
                    brg_d.link     = brg_q.mbox_addr[LINK_LSB +: 2];
                    brg_d.waddr    = brg_q.mbox_addr[RADDR_W-1:2];
                    brg_d.be       = (h_wdata[1:0] == CMD_WRITE) ?
                                     brg_q.mbox_addr[BE_LSB +: 4] : 4'hF;
                    brg_d.wdata    = brg_q.mbox_wdata;
                end else if (h_req && !is_local && !brg_q.dir_done) begin
                    issue          = 1'b1;
                    brg_d.st       = ST_WAIT;
                    brg_d.lreq     = 1'b1;
                    brg_d.mb_owner = 1'b0;
                    brg_d.we       = h_we;
                    brg_d.link     = link_sel;
                    brg_d.waddr    = h_addr[RADDR_W-1:2];
                    brg_d.be       = 4'hF;
                    brg_d.wdata    = h_wdata;
                end
            end
            ST_WAIT: begin
                if (l_ack) begin
                    brg_d.st = ST_IDLE;
                    if (l_err) brg_d.err = 1'b1;
                    if (brg_q.mb_owner) begin
                        if (!brg_q.we) brg_d.mbox_rdata = l_rdata;
                    end else begin
                        brg_d.dir_done  = 1'b1;
                        brg_d.dir_rdata = l_rdata;
                    end
                end else if (expired) begin
                    brg_d.st  = ST_IDLE;
                    brg_d.err = 1'b1;
                    if (brg_q.mb_owner) begin
                        if (!brg_q.we) brg_d.mbox_rdata = '1;
                    end else begin
                        brg_d.dir_done  = 1'b1;
                        brg_d.dir_rdata = '1;
                    end
                end
            end
            default: brg_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brg_q     <= '0;
            brg_q.st  <= ST_IDLE;
            brg_q.tmo <= TMO_RESET[TMO_W-1:0];
        end else begin
            brg_q <= brg_d;
        end
    end

    assign h_ready = h_req && (is_local || brg_q.dir_done);
    assign h_rdata = is_local ? local_rd : brg_q.dir_rdata;
    assign l_req   = brg_q.lreq;
    assign l_we    = brg_q.we;
    assign l_link  = brg_q.link;
    assign l_addr  = brg_q.waddr;
    assign l_be    = brg_q.be;
    assign l_wdata = brg_q.wdata;

    // R2: a request is a one-cycle pulse
    p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        l_req |=> !l_req);

    // R2: a request only goes out while the engine waits for it
    p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        l_req |-> run);

    // R6: a command during a transfer launches nothing
    p_cmd_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cmd_wr) |=> !l_req);

    // R7: expiry leaves the engine idle with the error flag set
    p_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !l_ack) |=> (brg_q.err && !run));

    // R9: the error flag only drops on an explicit clear
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (brg_q.err && !(cmd_wr && h_wdata[ERR_BIT])) |=> brg_q.err);

    // R10: a finished direct access is never still in flight
    p_dir_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brg_q.dir_done |-> !run);

endmodule

// File: tb/rlink_bridge_tb.sv
module rlink_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_req = 1'b0;
    logic        h_we = 1'b0;
    logic [31:2] h_addr = '0;
    logic [31:0] h_wdata = '0;
    logic        h_ready;
    logic [31:0] h_rdata;
    logic        l_req;
    logic        l_we;
    logic [1:0]  l_link;
    logic [13:0] l_addr;
    logic [3:0]  l_be;
    logic [31:0] l_wdata;
    logic        l_ack = 1'b0;
    logic        l_err = 1'b0;
    logic [31:0] l_rdata = '0;

    int nchk = 0;
    int nfail = 0;
    int nreq = 0;

    always #5 clk = ~clk;

    rlink_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_ready(h_ready), .h_rdata(h_rdata),
        .l_req(l_req), .l_we(l_we), .l_link(l_link), .l_addr(l_addr),
        .l_be(l_be), .l_wdata(l_wdata),
        .l_ack(l_ack), .l_err(l_err), .l_rdata(l_rdata)
    );

    // remote side model: register file per link, configurable latency
    logic [31:0] mem [0:3][0:15];
    int          lat = 0;
    logic        drop = 1'b0;
    logic        inject = 1'b0;
    logic        pend = 1'b0;
    int          pcnt = 0;
    logic        p_we;
    logic [1:0]  p_link;
    logic [13:0] p_addr;
    logic [3:0]  p_be;
    logic [31:0] p_wdata;
    logic [1:0]  cap_link;
    logic [13:0] cap_addr;
    logic [3:0]  cap_be;
    logic        cap_we;

    initial begin
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 16; j++) mem[i][j] = '0;
    end

    always @(negedge clk) begin
        l_ack = 1'b0;
        l_err = 1'b0;
        if (pend) begin
            if (pcnt == 0) begin
                if (p_we) begin
                    for (int b = 0; b < 4; b++)
                        if (p_be[b]) mem[p_link][p_addr[3:0]][8*b +: 8] = p_wdata[8*b +: 8];
                end else begin
                    l_rdata = mem[p_link][p_addr[3:0]];
                end
                l_ack = 1'b1;
                l_err = inject;
                pend  = 1'b0;
            end else begin
                pcnt = pcnt - 1;
            end
        end
        if (l_req) begin
            nreq++;
            cap_link = l_link; cap_addr = l_addr; cap_be = l_be; cap_we = l_we;
            if (!drop) begin
                pend = 1'b1; pcnt = lat;
                p_we = l_we; p_link = l_link; p_addr = l_addr; p_be = l_be; p_wdata = l_wdata;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_acc(input logic we, input logic [31:0] baddr,
                            input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        h_req = 1'b1; h_we = we; h_addr = baddr[31:2]; h_wdata = wd;
        #1;
        while (!h_ready) begin
            @(negedge clk);
            #1;
        end
        rd = h_rdata;
        @(posedge clk);
        #1;
        h_req = 1'b0; h_we = 1'b0;
    endtask

    task automatic host_wr(input logic [31:0] baddr, input logic [31:0] wd);
        logic [31:0] dummy;
        host_acc(1'b1, baddr, wd, dummy);
    endtask

    task automatic host_rd(input logic [31:0] baddr, output logic [31:0] rd);
        host_acc(1'b0, baddr, 32'h0, rd);
    endtask

    task automatic wait_idle(output logic [31:0] st);
        for (int k = 0; k < 5000; k++) begin
            host_rd(32'h10, st);
            if (!st[0]) break;
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [31:0] areg;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1, 32'h010F_0010, 32'h1122_3344, 32'h0},
        '{1'b0, 32'h010F_0013, 32'h0,         32'h1122_3344},
        '{1'b1, 32'h0105_0010, 32'hAABB_CCDD, 32'h0},
        '{1'b0, 32'h010F_0010, 32'h0,         32'h11BB_33DD},
        '{1'b1, 32'h020F_0020, 32'hCAFE_F00D, 32'h0},
        '{1'b0, 32'h020F_0020, 32'h0,         32'hCAFE_F00D},
        '{1'b1, 32'h0208_0020, 32'h5A00_0000, 32'h0},
        '{1'b0, 32'h020F_0022, 32'h0,         32'h5AFE_F00D},
        '{1'b0, 32'h0100_0010, 32'h0,         32'h11BB_33DD}
    };

    initial begin
        logic [31:0] rd;
        logic [31:0] st;
        int          r0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 link request idle", {31'b0, l_req}, 32'h0);
        host_rd(32'h10, rd); chk("R1 status", rd, 32'h0);
        host_rd(32'h20, rd); chk("R1 timeout default", rd, 32'd1024);
        chk("R1 no request", nreq, 0);

        // table walk: R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            lat = (i % 4) * 3;
            host_wr(32'h14, VEC[i].areg);
            if (VEC[i].wr) host_wr(32'h18, VEC[i].data);
            host_wr(32'h10, VEC[i].wr ? 32'h1 : 32'h3);
            wait_idle(st);
            chk("R2 busy clears", {31'b0, st[0]}, 32'h0);
            chk("R2 link index", {30'b0, cap_link}, {30'b0, VEC[i].areg[25:24]});
            chk("R4 word address", {18'b0, cap_addr}, {18'b0, VEC[i].areg[15:2]});
            chk("R2 direction", {31'b0, cap_we}, {31'b0, VEC[i].wr});
            if (VEC[i].wr) begin
                chk("R2 byte enables", {28'b0, cap_be}, {28'b0, VEC[i].areg[19:16]});
            end else begin
                chk("R3 read enables", {28'b0, cap_be}, 32'hF);
                host_rd(32'h1C, rd);
                chk("R3 R5 read result", rd, VEC[i].exp);
            end
        end

        // R6 command while busy is ignored
        lat = 20;
        host_wr(32'h14, 32'h030F_0030);
        host_wr(32'h18, 32'h600D_F00D);
        r0 = nreq;
        host_wr(32'h10, 32'h1);
        host_wr(32'h10, 32'h3);
        host_rd(32'h10, st);
        chk("R6 still busy", {31'b0, st[0]}, 32'h1);
        wait_idle(st);
        chk("R6 single request", nreq, r0 + 1);
        chk("R6 write kept", {31'b0, cap_we}, 32'h1);
        lat = 2;
        host_wr(32'h10, 32'h3);
        wait_idle(st);
        host_rd(32'h1C, rd);
        chk("R6 data landed", rd, 32'h600D_F00D);

        // R12 other command values
        r0 = nreq;
        host_wr(32'h10, 32'h0);
        host_wr(32'h10, 32'h2);
        repeat (5) @(posedge clk);
        host_rd(32'h10, st);
        chk("R12 no request", nreq, r0);
        chk("R12 not busy", st, 32'h0);

        // R11 / R7 timeout
        host_wr(32'h20, 32'd40);
        host_rd(32'h20, rd);
        chk("R11 timeout readback", rd, 32'd40);
        drop = 1'b1;
        host_wr(32'h14, 32'h010F_0010);
        host_wr(32'h10, 32'h3);
        wait_idle(st);
        chk("R7 error set", st, 32'h0000_8000);
        host_rd(32'h1C, rd);
        chk("R7 read all ones", rd, 32'hFFFF_FFFF);
        drop = 1'b0;

        // R9 sticky error and clear
        host_wr(32'h10, 32'h0);
        host_rd(32'h10, st);
        chk("R9 still set", {31'b0, st[15]}, 32'h1);
        host_wr(32'h10, 32'h8000);
        host_rd(32'h10, st);
        chk("R9 cleared", st, 32'h0);

        // R8 remote-flagged error
        inject = 1'b1;
        host_wr(32'h14, 32'h010F_0018);
        host_wr(32'h18, 32'h1);
        host_wr(32'h10, 32'h1);
        wait_idle(st);
        inject = 1'b0;
        chk("R8 error from remote", st, 32'h0000_8000);
        host_wr(32'h10, 32'h8000);

        // R10 direct path
        lat = 5;
        host_rd(32'h2000_0020, rd);
        chk("R10 direct read data", rd, 32'h5AFE_F00D);
        chk("R10 direct link", {30'b0, cap_link}, 32'h2);
        chk("R10 direct enables", {28'b0, cap_be}, 32'hF);
        chk("R10 direct address", {18'b0, cap_addr}, 32'h8);
        host_wr(32'h1000_0014, 32'h0000_0077);
        host_rd(32'h1000_0014, rd);
        chk("R10 direct write readback", rd, 32'h0000_0077);
        r0 = nreq;
        host_rd(32'h0000_0020, rd);
        repeat (4) @(posedge clk);
        chk("R10 local read", rd, 32'd40);
        chk("R10 local no link", nreq, r0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule